// File: doc/BRIEF.md
# Emergency Shutdown Input Detector

This block watches one active-low emergency shutdown pin. It synchronizes the pin into the clock domain and decides when a shutdown request has arrived. When a request is seen it sets a sticky request flag. While that flag is set, the block can raise an interrupt request, a high-impedance command for a group of output drivers, or both.

Detection has two kinds. The first is a plain falling edge. The second is a digital filter that needs sixteen low samples in a row. The filter samples at one of three rates, each a division of the block clock.

Software reaches the block through one 16-bit control/status word with a simple write strobe and read strobe. The detection method and the two enables can be set only once after reset. The flag is cleared by a read that sees it at 1, followed later by a write with a 0 in the flag position.

Top module: `estop_detect`

## Requirements
- R1: After reset, `rdData` reads 0x0000 and both `irqReq` and `hizCmd` are low.
- R2: With mode 00 in bits 1:0, a high-to-low transition of `pinN` sets the flag in bit 12 no later than the fourth rising clock edge after the change. A rising transition, or a pin that stays low, does not set it.
- R3: With mode 01, 10 or 11 in bits 1:0, the pin is sampled every 8, 16 or 128 clocks respectively. The flag in bit 12 sets once 16 consecutive samples are low. Any high sample restarts the count.
- R4: `irqReq` is high exactly while bit 12 (flag) and bit 8 (interrupt enable) are both 1.
- R5: `hizCmd` is high exactly while bit 12 (flag) and bit 9 (high-impedance enable) are both 1.
- R6: The first write after reset loads bits 1:0, 8 and 9. Every later write leaves those bits unchanged.
- R7: Writing 1 to bit 12 has no effect. Writing 0 to bit 12 clears the flag only if a read with `rdEn` saw bit 12 at 1 beforehand. Without such a read the flag stays set.
- R8: If a detection and a valid clear fall in the same cycle, the flag stays set.
- R9: Bits 7:2, 11:10 and 15:13 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| pinN | input | 1 | Asynchronous active-low shutdown pin |
| wrEn | input | 1 | Write strobe for the control/status word |
| rdEn | input | 1 | Read strobe; arms the flag clear when the flag reads 1 |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Current control/status word |
| irqReq | output | 1 | Interrupt request |
| hizCmd | output | 1 | High-impedance command for the guarded outputs |

## Verification
A register write takes effect at the clock edge that ends the write cycle. `irqReq` and `hizCmd` follow the flag in that same cycle.

In edge mode, a falling pin passes two synchronizer stages and then sets the flag at the third edge. The bench allows four edges before it samples.

In the filtered modes, the flag may arrive up to one sample period plus the synchronizer delay after the sixteenth low sample. The bench therefore holds the pin low for seventeen periods plus a small margin before it expects the flag. Before it expects no flag, it keeps every low stretch to fourteen periods.

The same-cycle priority case is placed so that the write falls exactly in the cycle in which the detection is raised. All comparisons take place on the falling clock edge.

// File: rtl/estop_pkg.sv
package estop_pkg;

  // Field positions inside the control/status word
  localparam int FLAG_POS = 12;
  localparam int IE_POS   = 8;
  localparam int HZ_POS   = 9;
  localparam int WORD_W   = 16;

  typedef enum logic [1:0] {
    MODE_EDGE  = 2'b00,
    MODE_RATEA = 2'b01,
    MODE_RATEB = 2'b10,
    MODE_RATEC = 2'b11
  } detMode_e;

  // control -> datapath
  typedef struct packed {
    detMode_e mode;
  } dpCtrl_t;

  // datapath -> control
  typedef struct packed {
    logic reqHit;
  } dpStat_t;

endpackage

// File: rtl/estop_datapath.sv
module estop_datapath
  import estop_pkg::*;
#(
  parameter int DIV_A   = 8,
  parameter int DIV_B   = 16,
  parameter int DIV_C   = 128,
  parameter int RUN_LEN = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pinN,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);

  localparam int RUN_W   = $clog2(RUN_LEN);
  localparam int N_RATES = 3;

  // two-stage synchronizer, idle level is high
  logic [1:0] syncQ;
  logic       prevPin;
  logic       syncPin;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      prevPin <= 1'b1;
    end else begin
      syncQ   <= {syncQ[0], pinN};
      prevPin <= syncQ[1];
    end
  end

  assign syncPin = syncQ[1];

  // one free-running divider per sampling rate
  logic [N_RATES-1:0] rateTick;

  for (genvar i = 0; i < N_RATES; i++) begin : g_rate
    localparam int DIV = (i == 0) ? DIV_A : (i == 1) ? DIV_B : DIV_C;
    localparam int DW  = $clog2(DIV);
    logic [DW-1:0] divCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        divCnt <= '0;
      end else if (divCnt == DW'(DIV - 1)) begin
        divCnt <= '0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end

    assign rateTick[i] = (divCnt == DW'(DIV - 1));
  end

  logic sampleStrobe;
  logic filtered;

  always_comb begin
    filtered = 1'b1;
    unique case (ctrl.mode)
      MODE_RATEA: sampleStrobe = rateTick[0];
      MODE_RATEB: sampleStrobe = rateTick[1];
      MODE_RATEC: sampleStrobe = rateTick[2];
      default: begin
        sampleStrobe = 1'b0;
        filtered     = 1'b0;
      end
    endcase
  end

  // consecutive-low run counter
  logic [RUN_W-1:0] runCnt;
  logic             runDone;

  assign runDone = sampleStrobe && !syncPin && (runCnt == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !filtered) begin
      runCnt <= '0;
    end else if (sampleStrobe) begin
      if (syncPin || runDone) begin
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  logic edgeHit;
  assign edgeHit = !filtered && prevPin && !syncPin;

  assign stat.reqHit = edgeHit || runDone;

endmodule

// File: rtl/estop_ctrl.sv
module estop_ctrl
  import estop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] wrData,
  input  dpStat_t           stat,
  output dpCtrl_t           ctrl,
  output logic [WORD_W-1:0] rdData,
  output logic              irqReq,
  output logic              hizCmd
);

  detMode_e modeQ;
  logic     ieQ;
  logic     hzQ;
  logic     cfgLock;
  logic     flagQ;
  logic     readArmed;

  // configuration fields: one write after reset, then frozen
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_EDGE;
      ieQ     <= 1'b0;
      hzQ     <= 1'b0;
      cfgLock <= 1'b0;
    end else if (wrEn && !cfgLock) begin
      modeQ   <= detMode_e'(wrData[1:0]);
      ieQ     <= wrData[IE_POS];
      hzQ     <= wrData[HZ_POS];
      cfgLock <= 1'b1;
    end
  end

  logic setEv;
  logic clrEv;

  assign setEv = stat.reqHit;
  assign clrEv = wrEn && !wrData[FLAG_POS] && readArmed && flagQ;

  // sticky flag, detection beats clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (setEv) begin
      flagQ <= 1'b1;
    end else if (clrEv) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readArmed <= 1'b0;
    end else if (clrEv && !setEv) begin
      readArmed <= 1'b0;
    end else if (rdEn && flagQ) begin
      readArmed <= 1'b1;
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[1:0]      = modeQ;
    rdData[IE_POS]   = ieQ;
    rdData[HZ_POS]   = hzQ;
    rdData[FLAG_POS] = flagQ;
  end

  assign irqReq    = flagQ && ieQ;
  assign hizCmd    = flagQ && hzQ;
  assign ctrl.mode = modeQ;

  // reserved write bits are accepted and dropped
  logic unusedWr;
  assign unusedWr = ^{wrData[15:13], wrData[11:10], wrData[7:2]};

endmodule

// File: rtl/estop_detect.sv
module estop_detect
  import estop_pkg::*;
#(
  parameter int DIV_A   = 8,
  parameter int DIV_B   = 16,
  parameter int DIV_C   = 128,
  parameter int RUN_LEN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irqReq,
  output logic        hizCmd
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;
  logic    reqHit;

  estop_datapath #(
    .DIV_A  (DIV_A),
    .DIV_B  (DIV_B),
    .DIV_C  (DIV_C),
    .RUN_LEN(RUN_LEN)
  ) u_dp (
    .clk (clk),
    .rstN(rstN),
    .pinN(pinN),
    .ctrl(dpCtrl),
    .stat(dpStat)
  );

  estop_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .wrData(wrData),
    .stat  (dpStat),
    .ctrl  (dpCtrl),
    .rdData(rdData),
    .irqReq(irqReq),
    .hizCmd(hizCmd)
  );

  assign reqHit = dpStat.reqHit;

endmodule

// File: rtl/estop_checker.sv
module estop_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [15:0] wrData,
  input logic [15:0] rdData,
  input logic        irqReq,
  input logic        hizCmd,
  input logic        reqHit
);

  logic seenWrite;
  logic armedSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenWrite <= 1'b0;
      armedSeen <= 1'b0;
    end else begin
      if (wrEn) seenWrite <= 1'b1;
      if (rdEn && rdData[12]) armedSeen <= 1'b1;
      else if (!rdData[12])   armedSeen <= 1'b0;
    end
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 16'hECFC) == 16'h0000); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[8] || !rdData[12]) |-> !irqReq); // R4

  AST_HIZ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[9] || !rdData[12]) |-> !hizCmd); // R5

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (seenWrite && wrEn) |=> $stable({rdData[9:8], rdData[1:0]})); // R6

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[12] && (!wrEn || wrData[12])) |=> rdData[12]); // R7

  AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdData[12]) |-> ($past(armedSeen) && $past(wrEn) && !$past(wrData[12]))); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    reqHit |=> rdData[12]); // R8

endmodule

bind estop_detect estop_checker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .rdEn  (rdEn),
  .wrData(wrData),
  .rdData(rdData),
  .irqReq(irqReq),
  .hizCmd(hizCmd),
  .reqHit(reqHit)
);

// File: tb/sim_estop_detect.sv
module sim_estop_detect;

  logic        clk = 1'b0;
  logic        rstN;
  logic        pinN;
  logic        wrEn;
  logic        rdEn;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        irqReq;
  logic        hizCmd;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  estop_detect u0 (
    .clk   (clk),
    .rstN  (rstN),
    .pinN  (pinN),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .wrData(wrData),
    .rdData(rdData),
    .irqReq(irqReq),
    .hizCmd(hizCmd)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // scoreboard queues
  string       qTag[$];
  logic [15:0] qRd[$];
  logic        qIrq[$];
  logic        qHiz[$];

  // monitor: compare pending expectations on the falling edge
  always @(negedge clk) begin
    while (qTag.size() > 0) begin
      string       t;
      logic [15:0] r;
      logic        ei;
      logic        eh;
      t  = qTag.pop_front();
      r  = qRd.pop_front();
      ei = qIrq.pop_front();
      eh = qHiz.pop_front();
      checks++;
      if (rdData !== r || irqReq !== ei || hizCmd !== eh) begin
        errors++;
        $display("FAIL %s: rdData=%h irq=%b hiz=%b expected rdData=%h irq=%b hiz=%b",
                 t, rdData, irqReq, hizCmd, r, ei, eh);
      end
    end
  end

  // driver side: all tasks start and end 1 time unit after a rising edge
  task automatic expectState(string tag, logic [15:0] rd, logic ei, logic eh);
    qTag.push_back(tag);
    qRd.push_back(rd);
    qIrq.push_back(ei);
    qHiz.push_back(eh);
    @(posedge clk);
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(logic [15:0] d);
    wrEn   = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic busRead();
    rdEn = 1'b1;
    @(posedge clk);
    #1;
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    rstN   = 1'b0;
    wrEn   = 1'b0;
    rdEn   = 1'b0;
    wrData = '0;
    pinN   = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  // filtered mode scenario
  task automatic runFiltered(string tag, logic [15:0] cfg, int div, logic ei, logic eh);
    busWrite(cfg);
    expectState({tag, " config"}, cfg, 1'b0, 1'b0);
    // interrupted low stretches never reach 16 consecutive low samples
    pinN = 1'b0; tick(14 * div);
    pinN = 1'b1; tick(2 * div);
    pinN = 1'b0; tick(14 * div);
    pinN = 1'b1; tick(2 * div);
    expectState({tag, " no trip on broken run"}, cfg, 1'b0, 1'b0);
    pinN = 1'b0; tick(17 * div + 6);
    expectState({tag, " trip after full run"}, cfg | 16'h1000, ei, eh);
    pinN = 1'b1;
  endtask

  initial begin
    doReset();
    expectState("R1 R9 reset value", 16'h0000, 1'b0, 1'b0);

    // ---- edge mode, both enables ----
    busWrite(16'hEFFC);
    expectState("R9 R6 first write, reserved dropped", 16'h0300, 1'b0, 1'b0);
    busWrite(16'h0001);
    expectState("R6 second write ignored", 16'h0300, 1'b0, 1'b0);
    pinN = 1'b0; tick(4);
    expectState("R2 R4 R5 falling edge trips", 16'h1300, 1'b1, 1'b1);
    busWrite(16'h0300);
    expectState("R7 clear without read ignored", 16'h1300, 1'b1, 1'b1);
    busWrite(16'h1300);
    expectState("R7 writing one has no effect", 16'h1300, 1'b1, 1'b1);
    busRead();
    busWrite(16'h0300);
    expectState("R7 read then write zero clears", 16'h0300, 1'b0, 1'b0);
    tick(6);
    expectState("R2 steady low does not retrip", 16'h0300, 1'b0, 1'b0);
    pinN = 1'b1; tick(6);
    expectState("R2 rising edge ignored", 16'h0300, 1'b0, 1'b0);
    pinN = 1'b0; tick(4);
    expectState("R2 second falling edge", 16'h1300, 1'b1, 1'b1);
    // R8: clear write lands in the cycle the detection is raised
    busRead();
    pinN = 1'b1; tick(4);
    pinN = 1'b0; tick(2);
    busWrite(16'h0300);
    expectState("R8 set wins over clear", 16'h1300, 1'b1, 1'b1);
    busRead();
    busWrite(16'h0300);
    expectState("R7 clear after priority case", 16'h0300, 1'b0, 1'b0);
    pinN = 1'b1;

    // ---- filtered modes ----
    doReset();
    runFiltered("R3 R4 R5 rate 8, no enables", 16'h0001, 8, 1'b0, 1'b0);
    doReset();
    runFiltered("R3 R5 rate 16, hiz only", 16'h0202, 16, 1'b0, 1'b1);
    doReset();
    runFiltered("R3 R4 rate 128, irq only", 16'h0103, 128, 1'b1, 1'b0);

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule